// File: doc/BRIEF.md
# Power State and Clock Enable Controller

This block holds the power state of a network controller and turns it into clock-enable signals for four gated domains: the host bus logic, the MAC core, the receive path and the PHY. Software picks one of three states by writing a 2-bit code into a power-mode register. The states are full operation (D0), a wake-capable sleep (D1) and a deep sleep (D2). In D1 only the receive path keeps its clock, so a wake-on-LAN detector downstream of it can still work. In D2 every gated domain is stopped.

The block leaves either sleep state and returns to D0 in two ways. Any host write to a separate wake-up register does it from D1 or D2. A wake event from the receive path does it from D1 only. The wake event arrives from another clock domain and first passes through a flop synchronizer. Whenever the block returns to D0 it also clears the power-mode register. The register decode and the state logic run on the free-running clock, so the wake-up register can always be reached. The clock enables are registered, and each one changes on the same edge as the state.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the state output is 2'b00 (D0), all four clock enables are 1, and a read of the power-mode register returns 0.
- R2: A write of code 2'b01 into bits [1:0] of the power-mode register (address PM_ADDR) moves the block to D1 at the sampling edge. From that edge `ce_rx` is 1, `ce_host`, `ce_mac` and `ce_phy` are 0, and `state` reads 2'b01.
- R3: A write of code 2'b10 moves the block to D2 at the sampling edge. `state` reads 2'b10 and all four clock enables are 0. A mode write is accepted in any state, including a direct move from D1 to D2 or from D2 to D1.
- R4: A write of the reserved code 2'b11 to the power-mode register leaves the state and the clock enables unchanged.
- R5: A write of any data to the wake-up register (address WAKE_ADDR) while in D1 or D2 returns the block to D0 at the sampling edge. All enables become 1 and the power-mode register reads 0.
- R6: In D1, a wake event that is high for one clock passes through SYNC_STAGES flops. The state is still D1 after SYNC_STAGES edges and is D0, with the register cleared, one edge later.
- R7: A wake event has no effect in D0 or in D2.
- R8: A write to the wake-up register while in D0, and a write to any address other than the two registers, change nothing.
- R9: If a synchronized wake event in D1 and a power-mode write land on the same edge, the wake wins and the block goes to D0.
- R10: `rd_data` is combinational on `reg_addr`. At PM_ADDR it returns the current 2-bit state code in bits [1:0] with zeros above. At every other address it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, never gated |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for writes and reads |
| reg_wdata | input | DATA_W | Write data; mode code in bits [1:0] |
| rd_data | output | DATA_W | Read data for `reg_addr` |
| wake_evt | input | 1 | Wake-on-LAN event, asynchronous |
| state | output | 2 | Current state: 00 D0, 01 D1, 10 D2 |
| ce_host | output | 1 | Clock enable, host bus domain |
| ce_mac | output | 1 | Clock enable, MAC domain |
| ce_rx | output | 1 | Clock enable, receive domain |
| ce_phy | output | 1 | Clock enable, PHY domain |

## Verification
The bench builds the block with its default parameters: 8-bit addresses and data, the mode register at 0x0B, the wake-up register at 0x1F and a two-flop synchronizer. With two stages the bench can see the wake event stay invisible for exactly two edges and act on the third. The same depth lets a mode write be placed on exactly the edge where the synchronized wake acts, which reaches the wake-priority case. The bench takes the stage count from a localparam of its own, so the wake timing it checks is worked out from the requirement rather than read from the design.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10
  } pwr_state_e;

  localparam int unsigned NUM_DOM = 4;
  // Domain bit order in the enable vector
  localparam int unsigned DOM_HOST = 0;
  localparam int unsigned DOM_MAC  = 1;
  localparam int unsigned DOM_RX   = 2;
  localparam int unsigned DOM_PHY  = 3;

  // Which domains run in a given state
  function automatic logic [NUM_DOM-1:0] enables_for(input pwr_state_e s);
    logic [NUM_DOM-1:0] e;
    case (s)
      PS_D0:   e = '1;
      PS_D1: begin
        e = '0;
        e[DOM_RX] = 1'b1;
      end
      default: e = '0;
    endcase
    return e;
  endfunction

  // Mode code legality: 2'b11 is reserved
  function automatic logic code_is_legal(input logic [1:0] c);
    return c != 2'b11;
  endfunction

endpackage

// File: rtl/pmc_wake_sync.sv
module pmc_wake_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign sync_out = async_in;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], async_in} ;
      end
      assign sync_out = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pmc_regif.sv
module pmc_regif
  import pmc_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 8,
  parameter int unsigned          DATA_W    = 8,
  parameter logic [ADDR_W-1:0]    PM_ADDR   = 8'h0B,
  parameter logic [ADDR_W-1:0]    WAKE_ADDR = 8'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  pwr_state_e        cur_state,
  output logic              pm_wr,
  output logic              pm_rsvd_wr,
  output pwr_state_e        pm_code,
  output logic              wake_wr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned HI_W = DATA_W - 2;

  logic hit_pm, hit_wake;
  logic [1:0] code_raw;
  logic unused_hi;

  assign hit_pm     = reg_wr && (reg_addr == PM_ADDR);
  assign hit_wake   = reg_wr && (reg_addr == WAKE_ADDR);
  assign code_raw   = reg_wdata[1:0];
  assign unused_hi  = ^reg_wdata[DATA_W-1:2];

  assign pm_wr      = hit_pm && code_is_legal(code_raw);
  assign pm_rsvd_wr = hit_pm && !code_is_legal(code_raw);
  assign pm_code    = pwr_state_e'(code_raw);
  assign wake_wr    = hit_wake;

  always_comb begin
    if (reg_addr == PM_ADDR) rd_data = {{HI_W{1'b0}}, cur_state};
    else                     rd_data = '0;
  end

  // R10: the register image must never show the reserved code
  a_r10_no_rsvd_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == PM_ADDR) |-> (rd_data[1:0] != 2'b11));
  // R4/R5 decode exclusivity: one address cannot be both registers
  a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm_wr && wake_wr));
endmodule

// File: rtl/pmc_state_fsm.sv
module pmc_state_fsm
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pm_wr,
  input  logic       pm_rsvd_wr,
  input  pwr_state_e pm_code,
  input  logic       wake_wr,
  input  logic       wake_sync,
  output pwr_state_e state_q,
  output pwr_state_e state_nxt,
  output logic       wake_taken
);
  logic host_wake, lan_wake;

  assign host_wake  = wake_wr && (state_q != PS_D0);
  assign lan_wake   = wake_sync && (state_q == PS_D1);
  assign wake_taken = host_wake || lan_wake;

  always_comb begin
    state_nxt = state_q;
    if (wake_taken)  state_nxt = PS_D0;   // wake beats a same-cycle mode write
    else if (pm_wr)  state_nxt = pm_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_D0;
    else        state_q <= state_nxt;
  end

  a_r5_host_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_wr && state_q != PS_D0) |=> (state_q == PS_D0));
  a_r6_lan_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_sync && state_q == PS_D1) |=> (state_q == PS_D0));
  a_r7_ignore_in_d2: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_sync && state_q == PS_D2 && !pm_wr && !wake_wr) |=> (state_q == PS_D2));
  a_r4_rsvd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_rsvd_wr && !wake_taken) |=> $stable(state_q));
  a_r3_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 2'b11);
endmodule

// File: rtl/pmc_ce_bank.sv
module pmc_ce_bank
  import pmc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  pwr_state_e         state_nxt,
  input  pwr_state_e         state_q,
  output logic [NUM_DOM-1:0] ce
);
  logic [NUM_DOM-1:0] want;
  assign want = enables_for(state_nxt);

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ce[d] <= 1'b1;
      else        ce[d] <= want[d];
    end
  end

  a_r1_d0_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_D0) |-> (ce == '1));
  a_r2_d1_rx_only: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_D1) |-> ($countones(ce) == 1 && ce[DOM_RX]));
  a_r3_d2_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_D2) |-> (ce == '0));
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 8,
  parameter int unsigned       DATA_W      = 8,
  parameter logic [ADDR_W-1:0] PM_ADDR     = 8'h0B,
  parameter logic [ADDR_W-1:0] WAKE_ADDR   = 8'h1F,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wake_evt,
  output logic [1:0]        state,
  output logic              ce_host,
  output logic              ce_mac,
  output logic              ce_rx,
  output logic              ce_phy
);
  pwr_state_e         state_q, state_nxt, pm_code;
  logic               pm_wr, pm_rsvd_wr, wake_wr, wake_sync, wake_taken;
  logic [NUM_DOM-1:0] ce;

  pmc_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(wake_evt), .sync_out(wake_sync)
  );

  pmc_regif #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PM_ADDR(PM_ADDR), .WAKE_ADDR(WAKE_ADDR)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cur_state(state_q), .pm_wr(pm_wr),
    .pm_rsvd_wr(pm_rsvd_wr), .pm_code(pm_code), .wake_wr(wake_wr),
    .rd_data(rd_data)
  );

  pmc_state_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pm_wr(pm_wr), .pm_rsvd_wr(pm_rsvd_wr),
    .pm_code(pm_code), .wake_wr(wake_wr), .wake_sync(wake_sync),
    .state_q(state_q), .state_nxt(state_nxt), .wake_taken(wake_taken)
  );

  pmc_ce_bank u_ce (
    .clk(clk), .rst_n(rst_n), .state_nxt(state_nxt), .state_q(state_q), .ce(ce)
  );

  assign state   = state_q;
  assign ce_host = ce[DOM_HOST];
  assign ce_mac  = ce[DOM_MAC];
  assign ce_rx   = ce[DOM_RX];
  assign ce_phy  = ce[DOM_PHY];

  // R5/R6: every wake lands in D0 with the mode register reading zero
  a_r6_wake_clears_reg: assert property (@(posedge clk) disable iff (!rst_n)
    wake_taken |=> (state == 2'b00 && ce_host && ce_mac && ce_rx && ce_phy));
endmodule

// File: tb/pwr_state_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_state_ctrl_tb;
  localparam int unsigned SYNC = 2;
  localparam logic [7:0] A_PM   = 8'h0B;
  localparam logic [7:0] A_WAKE = 8'h1F;
  // expected enable vectors, order {phy, rx, mac, host}
  localparam logic [3:0] E_D0 = 4'b1111;
  localparam logic [3:0] E_D1 = 4'b0100;
  localparam logic [3:0] E_D2 = 4'b0000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] rd_data;
  logic       wake_evt = 1'b0;
  logic [1:0] state;
  logic       ce_host, ce_mac, ce_rx, ce_phy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_state_ctrl #(
    .ADDR_W(8), .DATA_W(8), .PM_ADDR(A_PM), .WAKE_ADDR(A_WAKE), .SYNC_STAGES(SYNC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .wake_evt(wake_evt),
    .state(state), .ce_host(ce_host), .ce_mac(ce_mac), .ce_rx(ce_rx), .ce_phy(ce_phy)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] ces();
    return {ce_phy, ce_rx, ce_mac, ce_host};
  endfunction

  task automatic expect_state(input string req, input logic [1:0] s, input logic [3:0] e);
    chk(req, "state", {6'b0, s} == 8'h0 ? 8'h0 : 8'h0, 8'h0);
    checks--;
    chk(req, "state", {6'b0, state}, {6'b0, s});
    chk(req, "enables", {4'b0, ces()}, {4'b0, e});
  endtask

  // drive at a falling edge, released at the next falling edge (one posedge in between)
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
  endtask

  task automatic read_pm(input string req, input logic [7:0] exp);
    reg_addr = A_PM; #1;
    chk(req, "pm read", rd_data, exp);
    reg_addr = 8'h00;
  endtask

  task automatic t_reset();
    expect_state("R1", 2'b00, E_D0);
    read_pm("R1", 8'h00);
  endtask

  task automatic t_modes();
    wr(A_PM, 8'h01);                     // R2
    expect_state("R2", 2'b01, E_D1);
    read_pm("R10", 8'h01);
    wr(A_PM, 8'h02);                     // R3 direct D1 -> D2
    expect_state("R3", 2'b10, E_D2);
    read_pm("R10", 8'h02);
    wr(A_PM, 8'hFD);                     // upper bits ignored, code 01: D2 -> D1
    expect_state("R3", 2'b01, E_D1);
    wr(A_WAKE, 8'h00);
    expect_state("R5", 2'b00, E_D0);
  endtask

  task automatic t_reserved();
    wr(A_PM, 8'h01);
    wr(A_PM, 8'h03);                     // R4 reserved code in D1
    expect_state("R4", 2'b01, E_D1);
    wr(A_PM, 8'h02);
    wr(A_PM, 8'h03);                     // R4 reserved code in D2
    expect_state("R4", 2'b10, E_D2);
  endtask

  task automatic t_host_wake();
    wr(A_WAKE, 8'h5A);                   // R5 from D2
    expect_state("R5", 2'b00, E_D0);
    read_pm("R5", 8'h00);
    wr(A_PM, 8'h01);
    wr(A_WAKE, 8'hFF);                   // R5 from D1
    expect_state("R5", 2'b00, E_D0);
    read_pm("R5", 8'h00);
  endtask

  task automatic t_lan_wake();
    wr(A_PM, 8'h01);
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;     // 1 edge seen
    repeat (SYNC - 1) @(negedge clk);    // SYNC edges seen
    expect_state("R6", 2'b01, E_D1);
    @(negedge clk);                      // SYNC+1 edges
    expect_state("R6", 2'b00, E_D0);
    read_pm("R6", 8'h00);
  endtask

  task automatic t_ignored_wake();
    @(negedge clk); wake_evt = 1'b1;     // R7 in D0
    @(negedge clk); wake_evt = 1'b0;
    repeat (SYNC + 2) @(negedge clk);
    expect_state("R7", 2'b00, E_D0);
    wr(A_PM, 8'h02);
    @(negedge clk); wake_evt = 1'b1;     // R7 in D2
    @(negedge clk); wake_evt = 1'b0;
    repeat (SYNC + 2) @(negedge clk);
    expect_state("R7", 2'b10, E_D2);
    wr(A_WAKE, 8'h00);
  endtask

  task automatic t_no_effect_writes();
    wr(A_WAKE, 8'h01);                   // R8 wake write in D0
    expect_state("R8", 2'b00, E_D0);
    wr(A_PM, 8'h01);
    wr(8'h0C, 8'h00);                    // R8 other addresses
    wr(8'h1E, 8'h02);
    expect_state("R8", 2'b01, E_D1);
    reg_addr = A_WAKE; #1;
    chk("R10", "wake read", rd_data, 8'h00);
    reg_addr = 8'h33; #1;
    chk("R10", "other read", rd_data, 8'h00);
    reg_addr = 8'h00;
    wr(A_WAKE, 8'h00);
  endtask

  task automatic t_priority();
    wr(A_PM, 8'h01);
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
    repeat (SYNC - 1) @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_PM; reg_wdata = 8'h02;  // same edge as synced wake
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
    expect_state("R9", 2'b00, E_D0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_reserved();
    t_host_wake();
    t_lan_wake();
    t_ignored_wake();
    t_no_effect_writes();
    t_priority();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule